// File: doc/BRIEF.md
# Mixed-Sign and Fractional 8x8 Multiplier

This block multiplies two operands of `WIDTH` bits (8 by default) and returns a product twice as wide. A three-bit mode chooses how each operand is read: both unsigned, both two's complement, or operand A two's complement with operand B unsigned. A separate fractional bit shifts the product left by one place. This suits fixed-point values that carry a binary point just below the top bit. Alongside the product the block reports two flags. The zero flag reports a zero result. The carry flag holds the top bit of the product as it was before any fractional shift.

A caller pulses `start_i` for one cycle with the operands and mode. The block registers them and computes during the next cycle. It then raises `done_o` for one cycle, together with the new product and flags. A start that arrives while an operation is still in flight is dropped. A start presented in the same cycle as `done_o` is accepted, so operations can be issued every two cycles. Product and flags hold their values between completions. Writing the result into a register file and decoding instructions are left to the surrounding logic.

Top module: `smul_core`

## Requirements
- R1: With `mode_i[1:0]` = 00, both operands are unsigned and the unshifted product is A times B, taken modulo 2^(2*WIDTH).
- R2: With `mode_i[1:0]` = 01, both operands are two's complement and the unshifted product is their signed product, taken modulo 2^(2*WIDTH).
- R3: With `mode_i[1:0]` = 10, A is two's complement and B is unsigned. Code 11 behaves exactly like 00.
- R4: When `mode_i[2]` is 1 (fractional), `prod_o` is the unshifted product shifted left by one bit, so `prod_o[0]` is 0. When `mode_i[2]` is 0, `prod_o` is the unshifted product itself.
- R5: `flags_o[1]` (carry) equals bit 2*WIDTH-1 of the unshifted product. `flags_o[0]` (zero) is 1 exactly when the whole `prod_o` value being reported is zero.
- R6: If `start_i` is accepted at clock edge E, `done_o` is high for exactly one cycle, right after edge E+1, and `prod_o` and `flags_o` take their new values at that same edge. At all other times `prod_o` and `flags_o` hold their values.
- R7: A `start_i` sampled at edge E+1 (while busy) is ignored: it neither changes the result nor produces a second `done_o`. A `start_i` sampled at edge E+2 (the done cycle) is accepted.
- R8: After reset, `done_o`, `prod_o` and `flags_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a multiply |
| mode_i | input | 3 | Bits 1:0 select the signedness, bit 2 selects fractional |
| op_a_i | input | WIDTH | Operand A (the signed one in the mixed mode) |
| op_b_i | input | WIDTH | Operand B |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | 2*WIDTH | Product, held until the next completion |
| flags_o | output | 2 | Bit 0 zero flag, bit 1 carry flag |

## Verification
Two events can fall in the same cycle: the completion of one operation and the acceptance of the next. The sweep provokes this on every operation by raising the next start in the cycle where `done_o` is high. Each result is then judged against an arithmetic model, which also checks that no done pulse comes early or late. A start that arrives in the busy cycle is the contrasting case. The bench offers a different operand pair there and checks three things: the first result is reported unchanged, only one done pulse appears, and the output stays stable afterwards.

// File: rtl/smul_pkg.sv
package smul_pkg;

   localparam int MODE_W = 3;
   localparam int FLAG_W = 2;
   localparam int FLAG_Z = 0;
   localparam int FLAG_C = 1;
   localparam int FRAC_BIT = 2;

   typedef enum logic [1:0] {
      SGN_UU  = 2'b00,
      SGN_SS  = 2'b01,
      SGN_SU  = 2'b10,
      SGN_RSV = 2'b11
   } sign_mode_e;

   typedef struct packed {
      logic a_signed;
      logic b_signed;
      logic frac;
   } op_ctrl_t;

   function automatic op_ctrl_t decode_mode(input logic [MODE_W-1:0] m);
      op_ctrl_t c;
      c.frac = m[FRAC_BIT];
      unique case (sign_mode_e'(m[1:0]))
         SGN_SS:  begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
         SGN_SU:  begin c.a_signed = 1'b1; c.b_signed = 1'b0; end
         default: begin c.a_signed = 1'b0; c.b_signed = 1'b0; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/smul_opext.sv
module smul_opext #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] val_i,
   input  logic             is_signed_i,
   output logic [WIDTH:0]   ext_o
);
   initial assert (WIDTH >= 2) else $fatal(1, "smul_opext: WIDTH must be at least 2");

   logic fill;
   always_comb begin
      fill  = is_signed_i & val_i[WIDTH-1];
      ext_o = {fill, val_i};
   end
endmodule

// File: rtl/smul_pp_array.sv
module smul_pp_array #(
   parameter int WIDTH      = 8,
   parameter int ARRAY_IMPL = 0
) (
   input  logic [WIDTH:0]     a_ext_i,
   input  logic [WIDTH:0]     b_ext_i,
   output logic [2*WIDTH-1:0] raw_o
);
   localparam int PW   = 2 * WIDTH;
   localparam int ROWS = WIDTH + 1;

   initial assert (ARRAY_IMPL == 0 || ARRAY_IMPL == 1)
      else $fatal(1, "smul_pp_array: ARRAY_IMPL must be 0 or 1");

   logic [PW-1:0] a_wide;
   assign a_wide = {{(PW-WIDTH-1){a_ext_i[WIDTH]}}, a_ext_i};

   generate
      if (ARRAY_IMPL == 0) begin : g_operator
         logic [PW-1:0] b_wide;
         assign b_wide = {{(PW-WIDTH-1){b_ext_i[WIDTH]}}, b_ext_i};
         always_comb raw_o = PW'(a_wide * b_wide);
      end else begin : g_rows
         logic [PW-1:0] row  [ROWS];
         logic [PW-1:0] psum [ROWS+1];
         assign psum[0] = '0;
         for (genvar i = 0; i < ROWS; i++) begin : g_row
            logic [PW-1:0] shifted;
            assign shifted = a_wide << i;
            if (i < WIDTH) begin : g_pos
               assign row[i] = b_ext_i[i] ? shifted : '0;
            end else begin : g_neg
               assign row[i] = b_ext_i[i] ? (~shifted + PW'(1)) : '0;
            end
            assign psum[i+1] = psum[i] + row[i];
         end
         assign raw_o = psum[ROWS];
      end
   endgenerate
endmodule

// File: rtl/smul_post.sv
module smul_post import smul_pkg::*; #(
   parameter int WIDTH = 8
) (
   input  logic [2*WIDTH-1:0] raw_i,
   input  logic               frac_i,
   output logic [2*WIDTH-1:0] res_o,
   output logic [FLAG_W-1:0]  flags_o
);
   localparam int PW = 2 * WIDTH;

   always_comb begin
      res_o           = frac_i ? {raw_i[PW-2:0], 1'b0} : raw_i;
      flags_o         = '0;
      flags_o[FLAG_C] = raw_i[PW-1];
      flags_o[FLAG_Z] = (res_o == '0);
   end
endmodule

// File: rtl/smul_core.sv
module smul_core import smul_pkg::*; #(
   parameter int WIDTH      = 8,
   parameter int ARRAY_IMPL = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [MODE_W-1:0]    mode_i,
   input  logic [WIDTH-1:0]     op_a_i,
   input  logic [WIDTH-1:0]     op_b_i,
   output logic                 done_o,
   output logic [2*WIDTH-1:0]   prod_o,
   output logic [FLAG_W-1:0]    flags_o
);
   localparam int PW = 2 * WIDTH;

   initial assert (WIDTH >= 2 && WIDTH <= 32)
      else $fatal(1, "smul_core: WIDTH out of range");

   logic             busy_q;
   logic             accept;
   logic [WIDTH-1:0] a_q, b_q;
   op_ctrl_t         ctrl_q;

   assign accept = start_i & ~busy_q;

   // stage 1: capture operands, one busy cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         ctrl_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         a_q    <= op_a_i;
         b_q    <= op_b_i;
         ctrl_q <= decode_mode(mode_i);
      end else begin
         busy_q <= 1'b0;
      end
   end

   logic [WIDTH:0]  a_ext, b_ext;
   logic [PW-1:0]   raw, res;
   logic [FLAG_W-1:0] flg;

   smul_opext #(.WIDTH(WIDTH)) u_ext_a (.val_i(a_q), .is_signed_i(ctrl_q.a_signed), .ext_o(a_ext));
   smul_opext #(.WIDTH(WIDTH)) u_ext_b (.val_i(b_q), .is_signed_i(ctrl_q.b_signed), .ext_o(b_ext));

   smul_pp_array #(.WIDTH(WIDTH), .ARRAY_IMPL(ARRAY_IMPL)) u_array (
      .a_ext_i(a_ext), .b_ext_i(b_ext), .raw_o(raw));

   smul_post #(.WIDTH(WIDTH)) u_post (
      .raw_i(raw), .frac_i(ctrl_q.frac), .res_o(res), .flags_o(flg));

   // stage 2: publish result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         prod_o  <= '0;
         flags_o <= '0;
      end else begin
         done_o <= busy_q;
         if (busy_q) begin
            prod_o  <= res;
            flags_o <= flg;
         end
      end
   end

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ##1 done_o);                                            // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                               // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(prod_o) && $stable(flags_o));                  // R6
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i) |=> $stable(a_q) && $stable(b_q) && !busy_q);  // R7
   AST_FRAC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ctrl_q.frac) |-> !prod_o[0]);                           // R4
   AST_ZERO_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ctrl_q.frac && flags_o[FLAG_Z]) |-> !flags_o[FLAG_C]); // R5
endmodule

// File: tb/smul_core_bench.sv
`timescale 1ns/1ps
module smul_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [7:0]  op_a_i = '0, op_b_i = '0;
   logic        done_o;
   logic [15:0] prod_o;
   logic [1:0]  flags_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   smul_core u_smul_core (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .op_a_i(op_a_i), .op_b_i(op_b_i), .done_o(done_o),
      .prod_o(prod_o), .flags_o(flags_o));

   function automatic logic [15:0] ref_raw(input logic [7:0] a, input logic [7:0] b,
                                           input logic [2:0] m);
      int va, vb;
      va = int'(a);
      vb = int'(b);
      if ((m[1:0] == 2'b01 || m[1:0] == 2'b10) && a[7]) va = va - 256; // R2 R3
      if (m[1:0] == 2'b01 && b[7]) vb = vb - 256;                      // R2
      return 16'(va * vb);
   endfunction

   function automatic string mode_tag(input logic [2:0] m);
      string s;
      case (m[1:0])
         2'b00:   s = "R1";
         2'b01:   s = "R2";
         default: s = "R3";
      endcase
      if (m[2]) s = {s, "/R4"};
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_result(input logic [7:0] a, input logic [7:0] b, input logic [2:0] m);
      logic [15:0] raw, expv;
      raw  = ref_raw(a, b, m);
      expv = m[2] ? {raw[14:0], 1'b0} : raw;
      check(done_o == 1'b1, "R6 done", int'(done_o), 1);
      check(prod_o == expv, mode_tag(m), int'(prod_o), int'(expv));
      check(flags_o[1] == raw[15], "R5 carry", int'(flags_o[1]), int'(raw[15]));
      check(flags_o[0] == (expv == 16'h0), "R5 zero", int'(flags_o[0]), int'(expv == 16'h0));
   endtask

   // called at a negedge; returns at the negedge in the done cycle
   task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] m);
      start_i = 1'b1; op_a_i = a; op_b_i = b; mode_i = m;
      @(negedge clk);
      start_i = 1'b0; op_a_i = ~a; op_b_i = ~b;
      check(done_o == 1'b0, "R6 early done", int'(done_o), 0);
      @(negedge clk);
      check_result(a, b, m);
   endtask

   function automatic logic [7:0] sweep_val(input int i);
      return 8'((i * 4) | (i & 3));
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] corners [6];
      logic [15:0] held_p;
      logic [1:0]  held_f;
      corners = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFF};

      repeat (3) @(negedge clk);
      // R8 reset state
      check(done_o == 1'b0, "R8 done", int'(done_o), 0);
      check(prod_o == 16'h0, "R8 prod", int'(prod_o), 0);
      check(flags_o == 2'b00, "R8 flags", int'(flags_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // corner pairs in every mode code, back to back (R7 done-cycle accept)
      for (int m = 0; m < 8; m++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               run_op(corners[i], corners[j], 3'(m));

      // near-exhaustive sweep
      for (int m = 0; m < 8; m++)
         for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
               run_op(sweep_val(i), sweep_val(j), 3'(m));

      // R3: code 11 equals code 00 on a signed-looking pair
      run_op(8'h80, 8'hFF, 3'b011);
      check(prod_o == 16'h7F80, "R3 reserved as unsigned", int'(prod_o), 16'h7F80);
      // R4/R5: fractional -1 * -1 wraps, carry from unshifted product
      run_op(8'h80, 8'h80, 3'b101);
      check(prod_o == 16'h8000 && flags_o == 2'b00, "R4 R5 frac signed",
            int'({prod_o, flags_o}), int'({16'h8000, 2'b00}));

      // R7: start while busy is ignored
      start_i = 1'b1; op_a_i = 8'd12; op_b_i = 8'd10; mode_i = 3'b000;
      @(negedge clk);
      op_a_i = 8'd200; op_b_i = 8'd200; mode_i = 3'b001;
      check(done_o == 1'b0, "R7 busy no done", int'(done_o), 0);
      @(negedge clk);
      start_i = 1'b0;
      check(prod_o == 16'd120, "R7 busy start ignored", int'(prod_o), 120);
      held_p = prod_o;
      held_f = flags_o;
      @(negedge clk);
      check(done_o == 1'b0, "R7 no second done", int'(done_o), 0);
      @(negedge clk);
      check(done_o == 1'b0, "R7 no late done", int'(done_o), 0);
      check(prod_o == held_p && flags_o == held_f, "R6 hold", int'(prod_o), int'(held_p));

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule